// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block collects eight asynchronous interrupt lines from peripheral modules, cleans each of them through a synchronizer and a three-sample stability filter, and arbitrates the surviving requests by a programmable priority level. Level 0 is the most urgent and level 2 the least. When two requests share a level, the one with the lower source index wins. A global enable and a per-source enable gate the requests. The power-fail source, index 7, ignores the global enable and obeys only its own enable.

The CPU sequencer sees a one-system-cycle service strobe, `svc_o`. In that cycle it cancels the next fetch and pushes the return address, and it loads the instruction pointer from `vec_o`. The in-service level register `ips_o` takes the served level on the same edge. A running handler can be preempted only by a request of a strictly more urgent level, so at most two handlers nest above the base level. The sequencer signals a return from interrupt with `reti_i`. That cycle sets `ips_o` back to 11b (nothing in service) and takes no interrupt.

The filter runs on every undivided clock. The arbitration and service logic advance only on system ticks, marked by `clk_en_i`. The recognition latency counted in system cycles therefore shrinks as the divide ratio grows.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `ips_o` is 11b, `svc_o` is 0 and `flag_o` is all zero.
- R2: `flag_o[i]` goes high only after the synchronized `src_i[i]` has been sampled high on three consecutive undivided clocks. A pulse two clocks long never sets it. It is set whatever the enables are.
- R3: Let `clk_en_i` be held high and `src_i[i]` rise before clock edge 1 with an eligible source. Then `svc_o` is 0 after edge 6 and 1 after edge 7.
- R4: The level of source i is `prio_i[2i+1:2i]`. 0 is most urgent and 2 least urgent. A source whose level is 3 is never served.
- R5: Among eligible sources on the same level, the lowest index is served.
- R6: `ie_i[i]` gates source i. `gie_i`=0 masks every source except index 7.
- R7: A request is eligible only when its level is numerically below `ips_o`. The served level is written to `ips_o` on the service edge.
- R8: A service asserts `svc_o` for exactly one system cycle, with `vec_o` = 0x0020 + source index.
- R9: If `excp_win_i` is high on the system tick that would start service, the service starts one system tick later.
- R10: A system tick with `reti_i` high sets `ips_o` to 11b and starts no service. The pending request is sampled again, so service comes two ticks later.
- R11: Two services are separated by at least one system tick with `svc_o` low.
- R12: With `clk_en_i` high one clock in four, service still occurs with the correct vector, and `svc_o` stays high for four clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | undivided clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| clk_en_i | input | 1 | system tick (divided clock enable) |
| src_i | input | 8 | asynchronous interrupt lines |
| gie_i | input | 1 | global enable |
| ie_i | input | 8 | per-source enables |
| prio_i | input | 16 | 2-bit level per source |
| excp_win_i | input | 1 | current instruction opens an exception window |
| reti_i | input | 1 | return-from-interrupt cycle |
| flag_o | output | 8 | filtered source flags |
| svc_o | output | 1 | service strobe: cancel fetch, push return address |
| vec_o | output | 16 | vector address for the instruction pointer |
| ips_o | output | 2 | in-service level, 11b when idle |

## Verification
The hardest states to reach are those that need a second request to become eligible at an exact tick relative to a running service. Examples are the tick right after a service (back-to-back spacing), a tick that coincides with `reti_i` or an exception window, and preemption at a strictly more urgent level against a peer at equal level. The stimulus reaches these ticks by offsetting the raw line edges by single clocks against the known seven-edge latency. It also walks a handler nest through levels 2, 1 and 0. Random trials with `$urandom` enables, levels and lines are scored against an arbitration function in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC     = 8;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned VEC_W    = 16;
  localparam int unsigned SYNC_STG = 2;
  localparam int unsigned FILT_LEN = 3;
  localparam int unsigned PF_IDX   = 7;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0020;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t IPS_IDLE = '1;
endpackage

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter #(
  parameter int unsigned SYNC_STG = irq_pkg::SYNC_STG,
  parameter int unsigned FILT_LEN = irq_pkg::FILT_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flag_o
);
  logic [SYNC_STG-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q, hist_d;
  logic                flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else if (SYNC_STG == 1) sync_q <= raw_i;
    else sync_q <= {sync_q[SYNC_STG-2:0], raw_i};
  end

  assign hist_d = {hist_q[FILT_LEN-2:0], sync_q[SYNC_STG-1]};

  // flag moves only when the whole window agrees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      flag_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      if (&hist_d)       flag_q <= 1'b1;
      else if (~|hist_d) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC = irq_pkg::NSRC,
  parameter int unsigned LVL_W = irq_pkg::LVL_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       elig_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [LVL_W-1:0]       lvl_o
);
  // descending scan with <= lets the lowest index win a level tie
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!any_o || prio_i[i*LVL_W +: LVL_W] <= lvl_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = prio_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = irq_pkg::NSRC,
  parameter int unsigned PF_SRC = irq_pkg::PF_IDX,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clk_en_i,
  input  logic [N_SRC-1:0]       src_i,
  input  logic                   gie_i,
  input  logic [N_SRC-1:0]       ie_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  input  logic                   excp_win_i,
  input  logic                   reti_i,
  output logic [N_SRC-1:0]       flag_o,
  output logic                   svc_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic [LVL_W-1:0]       ips_o
);
  logic [N_SRC-1:0] flag, elig;
  logic             any;
  logic [IDX_W-1:0] win_idx, req_idx_q, svc_idx_q;
  lvl_t             win_lvl, req_lvl_q, ips_q;
  logic             req_v_q, svc_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_glitch_filter u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (src_i[g]),
      .flag_o (flag[g])
    );
    if (g == PF_SRC) begin : g_pf
      assign elig[g] = flag[g] & ie_i[g] & (prio_i[g*LVL_W +: LVL_W] < ips_q);
    end else begin : g_std
      assign elig[g] = flag[g] & ie_i[g] & gie_i & (prio_i[g*LVL_W +: LVL_W] < ips_q);
    end
  end

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .elig_i (elig),
    .prio_i (prio_i),
    .any_o  (any),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ips_q     <= IPS_IDLE;
      req_v_q   <= 1'b0;
      req_idx_q <= '0;
      req_lvl_q <= IPS_IDLE;
      svc_q     <= 1'b0;
      svc_idx_q <= '0;
    end else if (clk_en_i) begin
      svc_q <= 1'b0;
      if (reti_i) begin
        ips_q   <= IPS_IDLE;
        req_v_q <= 1'b0;
      end else if (req_v_q) begin
        if (!excp_win_i) begin
          svc_q     <= 1'b1;
          svc_idx_q <= req_idx_q;
          ips_q     <= req_lvl_q;
          req_v_q   <= 1'b0;
        end
      end else begin
        req_v_q   <= any;
        req_idx_q <= win_idx;
        req_lvl_q <= win_lvl;
      end
    end
  end

  assign flag_o = flag;
  assign svc_o  = svc_q;
  assign vec_o  = VEC_BASE + VEC_W'(svc_idx_q);
  assign ips_o  = ips_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = irq_pkg::NSRC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_i,
  input logic             reti_i,
  input logic             svc_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [LVL_W-1:0] ips_o
);
  // R10
  p_reti_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && reti_i) |=> (ips_o == IPS_IDLE && !svc_o));
  // R11
  p_svc_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_o && clk_en_i) |=> !svc_o);
  // R7
  p_strict_preempt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(svc_o) |-> (ips_o < $past(ips_o)));
  // R8
  p_vec_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |-> (vec_o >= VEC_BASE && vec_o < VEC_BASE + VEC_W'(N_SRC)));
  // R4
  p_lvl_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |-> (ips_o != IPS_IDLE));
  // R12
  p_svc_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_o && !clk_en_i) |=> svc_o);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (.*);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_i;
  logic [7:0]  src_i = '0;
  logic        gie_i = 1'b1;
  logic [7:0]  ie_i = '1;
  logic [15:0] prio_i = '0;
  logic        excp_win_i = 1'b0;
  logic        reti_i = 1'b0;
  logic [7:0]  flag_o;
  logic        svc_o;
  logic [15:0] vec_o;
  logic [1:0]  ips_o;

  int total = 0, bad = 0, div_r = 1, dcnt = 0, cyc = 0;
  bit done = 0;

  irq_prio_ctrl dut (.*);

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (dcnt >= div_r - 1) dcnt = 0; else dcnt = dcnt + 1;
    clk_en_i = (dcnt == 0);
  end
  initial clk_en_i = 1'b1;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; src_i = '0; reti_i = 0; excp_win_i = 0; div_r = 1;
    gie_i = 1; ie_i = '1; prio_i = '0;
    step(2); rst_ni = 1'b1; step(2);
  endtask

  task automatic reti_pulse();
    reti_i = 1; step(1); reti_i = 0; step(1);
  endtask

  function automatic int model(logic [7:0] s, logic [7:0] ie, logic g,
                               logic [15:0] pr, int ips);
    int best = -1, bl = 4;
    for (int i = 0; i < 8; i++) begin
      int l = int'(pr[2*i +: 2]);
      if (s[i] && ie[i] && (g || i == 7) && l < ips && l < bl) begin
        best = i; bl = l;
      end
    end
    return best;
  endfunction

  // raise lines, expect service at exactly 7 negedges (or none within 12)
  task automatic raise_expect(logic [7:0] m, int exp_idx, int exp_lvl, string req);
    src_i = src_i | m;
    step(6);
    chk({req, " early"}, svc_o, 0);
    step(1);
    if (exp_idx < 0) begin
      chk({req, " none"}, svc_o, 0);
      step(5);
      chk({req, " none late"}, svc_o, 0);
    end else begin
      chk({req, " svc"}, svc_o, 1);
      chk({req, " vec"}, vec_o, 16'h20 + exp_idx);
      chk({req, " ips"}, ips_o, exp_lvl);
    end
  endtask

  initial begin
    int first;
    int n_svc;
    logic [15:0] v;
    step(1);
    // R1
    chk("R1 ips", ips_o, 3);
    chk("R1 svc", svc_o, 0);
    chk("R1 flag", flag_o, 0);
    do_reset();

    // R3 exact latency, R8 vector and one-cycle strobe
    prio_i[2*5 +: 2] = 2'd1;
    raise_expect(8'h20, 5, 1, "R3");
    step(1);
    chk("R8 one cycle", svc_o, 0);
    chk("R11 no repeat", svc_o, 0);

    // R2 short pulse ignored, flag set while disabled
    do_reset();
    src_i = 8'h08; step(2); src_i = 0; step(10);
    chk("R2 glitch flag", flag_o[3], 0);
    chk("R2 glitch svc", svc_o, 0);
    ie_i = 8'h00;
    src_i = 8'h08; step(8);
    chk("R2 flag when disabled", flag_o[3], 1);
    chk("R6 local mask", svc_o, 0);

    // R6 global mask except power-fail source 7
    do_reset();
    gie_i = 0;
    raise_expect(8'h81, 7, 0, "R6 pf");
    do_reset();
    gie_i = 0;
    raise_expect(8'h02, -1, 0, "R6 gie");

    // R4 level 3 never served
    do_reset();
    prio_i = 16'h0030;
    raise_expect(8'h04, -1, 0, "R4");

    // R5 tie goes to lowest index
    do_reset();
    prio_i = 16'h0044;   // src1=1, src3=1
    raise_expect(8'h0A, 1, 1, "R5");

    // R7 nesting: 2 -> 1, equal 1 blocked, 0 preempts
    do_reset();
    prio_i = '0;
    prio_i[2*2 +: 2] = 2; prio_i[2*4 +: 2] = 1;
    prio_i[2*5 +: 2] = 1; prio_i[2*6 +: 2] = 0;
    raise_expect(8'h04, 2, 2, "R7 l2");
    raise_expect(8'h10, 4, 1, "R7 l1");
    raise_expect(8'h20, -1, 0, "R7 equal");
    chk("R7 ips kept", ips_o, 1);
    raise_expect(8'h40, 6, 0, "R7 l0");
    src_i = 0; step(6);
    reti_pulse();
    chk("R10 ips idle", ips_o, 3);

    // R9 exception window delays by one tick
    do_reset();
    src_i = 8'h01; step(6);
    excp_win_i = 1; step(1); excp_win_i = 0;
    chk("R9 held", svc_o, 0);
    step(1);
    chk("R9 late svc", svc_o, 1);
    chk("R9 vec", vec_o, 16'h20);

    // R10 reti tick takes no interrupt
    do_reset();
    src_i = 8'h02; step(6);
    reti_i = 1; step(1); reti_i = 0;
    chk("R10 blocked", svc_o, 0);
    step(1);
    chk("R10 resample", svc_o, 0);
    step(1);
    chk("R10 svc", svc_o, 1);

    // R11 back-to-back spacing
    do_reset();
    prio_i[2*1 +: 2] = 1; prio_i[2*2 +: 2] = 0;
    src_i = 8'h02; step(1); src_i = 8'h06; step(6);
    chk("R11 first", vec_o, 16'h21);
    chk("R11 first svc", svc_o, 1);
    step(1);
    chk("R11 gap", svc_o, 0);
    step(1);
    chk("R11 second", svc_o, 1);
    chk("R11 second vec", vec_o, 16'h22);

    // R12 divide by four
    do_reset();
    div_r = 4;
    src_i = 8'h10;
    first = -1; n_svc = 0;
    for (int k = 0; k < 60; k++) begin
      step(1);
      if (svc_o) begin
        n_svc++;
        if (first < 0) begin first = k; v = vec_o; end
      end
    end
    chk("R12 served", first >= 0, 1);
    chk("R12 vec", v, 16'h24);
    chk("R12 width", n_svc, 4);

    // random trials
    for (int t = 0; t < 60; t++) begin
      logic [7:0] s, ie;
      logic g;
      logic [15:0] pr;
      int e, got, cnt;
      do_reset();
      s = 8'($urandom); ie = 8'($urandom); g = 1'($urandom); pr = 16'($urandom);
      ie_i = ie; gie_i = g; prio_i = pr;
      e = model(s, ie, g, pr, 3);
      src_i = s;
      got = -1; cnt = 0;
      for (int k = 0; k < 14; k++) begin
        step(1);
        if (svc_o) begin cnt++; if (got < 0) got = int'(vec_o) - 16'h20; end
      end
      chk("R5 R6 random idx", got, e);
      chk("R8 random count", cnt, (e < 0) ? 0 : 1);
      if (e >= 0) chk("R7 random ips", ips_o, int'(pr[2*e +: 2]));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    $urandom(7);
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule